// File: doc/BRIEF.md
# Microcode RAM Byte-Window Loader

This block holds the instruction store of a small sequencer: 512 words of 32 bits. Software reaches the store through an 8-bit register bus. A single data window carries the bytes. A word address comes from a full low address register and a one-bit high address register. A hidden byte-lane counter decides which byte of the word the next data-window access touches. When software writes four bytes in a row, the block assembles one word, writes it to memory in a single operation, and moves to the next word. Reads step through the window in the same way.

A control register holds a load-enable bit and a sequencer-reset bit. While load enable is clear, accesses to the window have no effect. While sequencer reset is set, the word address and the lane counter stay at zero. Both bits also leave the block as outputs. A separate fetch port lets the sequencer core read whole words by address.

Top module: `ucode_loader`

## Requirements
- R1: The bus register select encodes 0 = control, 1 = data window, 2 = address low, 3 = address high. Control bit 0 is load enable and bit 1 is sequencer reset. Control reads back in bits [1:0] with the upper bits zero. Address high keeps only bit 0 and reads back with the upper bits zero. After reset every register reads zero and both control outputs are low.
- R2: Data-window writes fill the word least significant byte first. The fourth write puts the whole 32-bit word into memory at the current word address. The first three writes leave memory unchanged.
- R3: The word address increases by one after the fourth data-window access, whether that access is a read or a write, and not after the first three.
- R4: A data-window read returns, on bus_rdata in the cycle after the strobe, the byte of the addressed word that the lane counter selects. Lane 0 is bits 7:0.
- R5: A write to either address register resets the lane counter to zero, so the next data-window access starts a new word.
- R6: While load enable is 0, data-window accesses leave memory, the word address and the lane counter unchanged, and a data-window read returns 0.
- R7: The word address wraps from 511 to 0.
- R8: While sequencer reset is 1, the word address and the lane counter are held at zero and data-window accesses are ignored. The seq_rst output follows the bit.
- R9: fetch_word presents the memory word at fetch_addr one cycle later. In the cycle a word is committed to that same address, the fetch still returns the previous contents.
- R10: The address registers read back the current word address, including the effect of the automatic increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| load_en | output | 1 | Load-enable control bit |
| seq_rst | output | 1 | Sequencer-reset control bit |
| fetch_addr | input | 9 | Core fetch word address |
| fetch_word | output | 32 | Registered fetch word |

## Verification
Two functions can act in the same cycle: the core fetch port reading a word, and the commit of the fourth window byte to that same word. The bench holds fetch_addr on a word, fills three bytes, and issues the fourth write. It then requires the old word in the cycle right after the commit edge and the new word one cycle later. A second overlap is checked as well: a sequencer-reset request arriving while a word is half built. The bench judges it by the address read back and by where the next complete word ends up.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ALO  = 2'd2,
    SEL_AHI  = 2'd3
  } sel_e;

  localparam int unsigned CTRL_LOAD_BIT = 0;
  localparam int unsigned CTRL_RST_BIT  = 1;
endpackage

// File: rtl/ucl_ctrl.sv
module ucl_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic load_i,
  input  logic srst_i,
  output logic load_en_o,
  output logic seq_rst_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load_en_o <= 1'b0;
      seq_rst_o <= 1'b0;
    end else if (wr_i) begin
      load_en_o <= load_i;
      seq_rst_o <= srst_i;
    end
  end
endmodule

// File: rtl/ucl_ptr.sv
module ucl_ptr #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned HI_W   = ADDR_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_rst_i,
  input  logic              acc_i,
  input  logic              alo_wr_i,
  input  logic              ahi_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;

  always_ff @(posedge clk) begin
    if (rst || seq_rst_i) begin
      addr_o <= '0;
      lane_o <= '0;
    end else if (alo_wr_i) begin
      addr_o[BYTE_W-1:0] <= wdata_i;
      lane_o <= '0;
    end else if (ahi_wr_i) begin
      addr_o[ADDR_W-1:BYTE_W] <= wdata_i[HI_W-1:0];
      lane_o <= '0;
    end else if (acc_i) begin
      if (lane_o == LAST_LANE) begin
        lane_o <= '0;
        addr_o <= addr_o + ADDR_W'(1);
      end else begin
        lane_o <= lane_o + LANE_W'(1);
      end
    end
  end

  // R3: the address moves only on a last-lane access or an explicit load
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!seq_rst_i && !alo_wr_i && !ahi_wr_i && !(acc_i && lane_o == LAST_LANE))
      |=> $stable(addr_o));

  // R7: the address wraps from the top word to zero
  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!seq_rst_i && !alo_wr_i && !ahi_wr_i && acc_i && lane_o == LAST_LANE && addr_o == TOP_ADDR)
      |=> addr_o == '0);

  // R5: an address register write restarts the lane count
  assert_lane_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!seq_rst_i && (alo_wr_i || ahi_wr_i)) |=> lane_o == '0);

  // R8: the sequencer reset zeroes the pointer
  assert_seq_reset_R8: assert property (@(posedge clk) disable iff (rst)
    seq_rst_i |=> (addr_o == '0 && lane_o == '0));
endmodule

// File: rtl/ucl_stage.sv
module ucl_stage #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wacc_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] hold_q [LANES-1];

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) hold_q[g] <= '0;
      else if (wacc_i && lane_i == LANE_W'(g)) hold_q[g] <= wdata_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = hold_q[g];
  end

  assign word_o[(LANES-1)*BYTE_W +: BYTE_W] = wdata_i;
endmodule

// File: rtl/ucl_ram.sv
module ucl_ram #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] faddr_i,
  output logic [WORD_W-1:0] fdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    fdata_o <= mem[faddr_i];
  end
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned HI_W   = ADDR_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              load_en,
  output logic              seq_rst,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] fetch_word
);
  import ucl_pkg::*;

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  sel_e              sel;
  logic              acc, wacc, racc, mem_we;
  logic [ADDR_W-1:0] addr;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] commit_word, rd_word;
  logic [BYTE_W-1:0] rd_bytes [LANES];

  assign sel  = sel_e'(bus_sel);
  assign acc  = (bus_wr || bus_rd) && sel == SEL_DATA && load_en && !seq_rst;
  assign wacc = acc && bus_wr;
  assign racc = acc && !bus_wr;
  assign mem_we = wacc && lane == LAST_LANE;

  ucl_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (bus_wr && sel == SEL_CTRL),
    .load_i    (bus_wdata[CTRL_LOAD_BIT]),
    .srst_i    (bus_wdata[CTRL_RST_BIT]),
    .load_en_o (load_en),
    .seq_rst_o (seq_rst)
  );

  ucl_ptr #(.BYTE_W(BYTE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .seq_rst_i (seq_rst),
    .acc_i     (acc),
    .alo_wr_i  (bus_wr && sel == SEL_ALO),
    .ahi_wr_i  (bus_wr && sel == SEL_AHI),
    .wdata_i   (bus_wdata),
    .addr_o    (addr),
    .lane_o    (lane)
  );

  ucl_stage #(.BYTE_W(BYTE_W), .LANES(LANES)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .wacc_i  (wacc),
    .lane_i  (lane),
    .wdata_i (bus_wdata),
    .word_o  (commit_word)
  );

  ucl_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (addr),
    .wdata_i (commit_word),
    .raddr_i (addr),
    .rdata_o (rd_word),
    .faddr_i (fetch_addr),
    .fdata_o (fetch_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_rbyte
    assign rd_bytes[g] = rd_word[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      unique case (sel)
        SEL_CTRL: begin
          bus_rdata[CTRL_LOAD_BIT] <= load_en;
          bus_rdata[CTRL_RST_BIT]  <= seq_rst;
        end
        SEL_DATA: if (racc) bus_rdata <= rd_bytes[lane];
        SEL_ALO:  bus_rdata <= addr[BYTE_W-1:0];
        SEL_AHI:  bus_rdata <= BYTE_W'(addr[ADDR_W-1:BYTE_W]);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R6: a window read with loading disabled returns zero
  assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && sel == SEL_DATA && !load_en) |=> bus_rdata == '0);

  // R1: unused high-address bits read as zero
  assert_hi_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_AHI) |=> bus_rdata[BYTE_W-1:HI_W] == '0);

  // R2: memory is written only while loading is enabled and the sequencer is released
  assert_commit_gated_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (load_en && !seq_rst && bus_wr));
endmodule

// File: tb/tb_ucode_loader.sv
`timescale 1ns/1ps
module tb_ucode_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        load_en, seq_rst;
  logic [8:0]  fetch_addr = 9'd0;
  logic [31:0] fetch_word;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [1:0] S_CTRL = 2'd0, S_DATA = 2'd1, S_ALO = 2'd2, S_AHI = 2'd3;

  always #2.5 clk = ~clk;

  ucode_loader dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_en(load_en), .seq_rst(seq_rst),
    .fetch_addr(fetch_addr), .fetch_word(fetch_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); bus_sel = s; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_addr(input logic [8:0] a);
    wr(S_AHI, {7'd0, a[8]});
    wr(S_ALO, a[7:0]);
  endtask

  task automatic put_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(S_DATA, w[i*8 +: 8]);
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] w);
    @(negedge clk); fetch_addr = a;
    @(negedge clk); w = fetch_word;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    check("R1 load_en after reset", load_en, 0);
    check("R1 seq_rst after reset", seq_rst, 0);
    rd(S_CTRL, b); check("R1 ctrl after reset", b, 0);
    rd(S_ALO, b);  check("R1 addr lo after reset", b, 0);
    rd(S_AHI, b);  check("R1 addr hi after reset", b, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] b;
    wr(S_AHI, 8'hFF); rd(S_AHI, b); check("R1 addr hi keeps bit0", b, 8'h01);
    wr(S_CTRL, 8'hFF); rd(S_CTRL, b); check("R1 ctrl readback", b, 8'h03);
    check("R8 seq_rst output", seq_rst, 1);
    wr(S_CTRL, 8'h01); rd(S_CTRL, b); check("R1 ctrl load only", b, 8'h01);
    check("R1 load_en output", load_en, 1);
  endtask

  task automatic t_write_read();
    logic [7:0] b; logic [31:0] w;
    set_addr(9'd5);
    put_word(32'h11223344);
    peek(9'd5, w); check("R2 word committed", w, 32'h11223344);
    rd(S_ALO, b); check("R3 R10 address advanced", b, 8'd6);
    set_addr(9'd5);
    for (int i = 0; i < 4; i++) begin
      rd(S_DATA, b); check("R4 read byte lane", b, (32'h11223344 >> (8*i)) & 32'hFF);
      if (i == 2) begin
        logic [7:0] a; rd(S_ALO, a); check("R3 no advance before last byte", a, 8'd5);
      end
    end
    rd(S_ALO, b); check("R3 advance after read", b, 8'd6);
  endtask

  task automatic t_partial();
    logic [7:0] b; logic [31:0] w;
    set_addr(9'd7); put_word(32'hCAFEF00D);
    set_addr(9'd7);
    wr(S_DATA, 8'hAA); wr(S_DATA, 8'hBB);
    peek(9'd7, w); check("R2 partial leaves memory", w, 32'hCAFEF00D);
    wr(S_ALO, 8'd7);
    put_word(32'h01020304);
    peek(9'd7, w); check("R5 lane restart on address write", w, 32'h01020304);
    rd(S_ALO, b); check("R5 address after restart", b, 8'd8);
  endtask

  task automatic t_disabled();
    logic [7:0] b; logic [31:0] w;
    set_addr(9'd9); put_word(32'h55667788);
    set_addr(9'd9);
    wr(S_DATA, 8'hE1);
    wr(S_CTRL, 8'h00);
    put_word(32'hDEADBEEF);
    rd(S_DATA, b); check("R6 disabled read zero", b, 0);
    peek(9'd9, w); check("R6 memory untouched", w, 32'h55667788);
    rd(S_ALO, b); check("R6 address untouched", b, 8'd9);
    wr(S_CTRL, 8'h01);
    wr(S_DATA, 8'hE2); wr(S_DATA, 8'hE3); wr(S_DATA, 8'hE4);
    peek(9'd9, w); check("R6 lane preserved", w, 32'hE4E3E2E1);
  endtask

  task automatic t_wrap();
    logic [7:0] b; logic [31:0] w;
    set_addr(9'd511); put_word(32'h0BADC0DE);
    rd(S_ALO, b); check("R7 wrap low", b, 0);
    rd(S_AHI, b); check("R7 wrap high", b, 0);
    peek(9'd511, w); check("R7 top word written", w, 32'h0BADC0DE);
  endtask

  task automatic t_seq_reset();
    logic [7:0] b; logic [31:0] w;
    set_addr(9'd0); put_word(32'hA0A0A0A0);
    set_addr(9'h20); wr(S_DATA, 8'h99);
    wr(S_CTRL, 8'h03);
    rd(S_ALO, b); check("R8 address held zero", b, 0);
    put_word(32'h12345678);
    wr(S_ALO, 8'h44);
    rd(S_ALO, b); check("R8 address load ignored", b, 0);
    peek(9'd0, w); check("R8 writes ignored in reset", w, 32'hA0A0A0A0);
    wr(S_CTRL, 8'h01);
    check("R8 seq_rst released", seq_rst, 0);
    put_word(32'h87654321);
    peek(9'd0, w); check("R8 lane cleared by reset", w, 32'h87654321);
  endtask

  task automatic t_collide();
    logic [31:0] w;
    set_addr(9'h40); put_word(32'h11111111);
    @(negedge clk); fetch_addr = 9'h40;
    set_addr(9'h40);
    wr(S_DATA, 8'h04); wr(S_DATA, 8'h03); wr(S_DATA, 8'h02);
    @(negedge clk); bus_sel = S_DATA; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R9 fetch old word at commit", fetch_word, 32'h11111111);
    @(negedge clk);
    check("R9 fetch new word after commit", fetch_word, 32'h01020304);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_write_read();
    t_partial();
    t_disabled();
    t_wrap();
    t_seq_reset();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule